// File: doc/BRIEF.md
# Edge/Level Interrupt Delivery Engine

This block sits between the interrupt input pins of an I/O interrupt controller and the message fabric that carries interrupts to processor-side controllers. Each pin reports its line level through a strobe. The block keeps a request bit per pin, a remote-pending flag for level-triggered pins and a delivered bit for edge-triggered pins. It turns pending requests into delivery messages that carry the destination, vector, destination mode, delivery mode and trigger mode. End-of-interrupt (EOI) notifications come back with a vector and a trigger mode. They release level-triggered pins and, when the line is still asserted, start a new delivery.

The redirection entry fields for every pin (mask, trigger mode, vector, destination, modes) arrive as plain inputs from a register block outside this one. When software rewrites an entry, that block pulses `ent_wr_i` for the pin. Outgoing messages use a valid/ready handshake. Once `msg_valid_o` is high, the message and all its fields stay fixed until a cycle with `msg_ready_i` high. That cycle is the transfer. `msg_hit_i`, sampled in the transfer cycle, reports whether at least one destination accepted the message. When several pins are pending, the block serves them one message per transfer, lowest pin number first.

A level-triggered interrupt whose line never drops would flood the processors with redeliveries after every EOI. The block counts back-to-back EOI-driven redeliveries per pin. When a pin reaches `STORM_LIMIT`, its redelivery waits `DEFER_CYCLES` clock cycles.

Top module: `intr_delivery_engine`

## Requirements
- R1: A strobe with level low clears the pin's request bit and delivers nothing. For a level-triggered pin it also cancels any delivery not yet loaded into the message slot.
- R2: For an edge-triggered pin (`ent_level_i` = 0), a strobe with level high leads to a delivery only if the request bit was clear. If the bit was already set, nothing is delivered and `drop_o` for that pin is high in the cycle after the strobe.
- R3: For a level-triggered pin (`ent_level_i` = 1), a strobe with level high while the remote-pending flag is set delivers nothing and raises `drop_o` in the next cycle.
- R4: A masked pin (`ent_mask_i` = 1) never produces a message. A high strobe still sets its request bit.
- R5: A transfer of a level-triggered message with `msg_hit_i` = 1 sets the pin's remote-pending flag. With `msg_hit_i` = 0 the flag stays clear.
- R6: An EOI with `eoi_level_i` = 1 clears the remote-pending flag of every level-triggered pin whose vector equals `eoi_vector_i`. If that pin is unmasked and its request bit is set, it is delivered again. An EOI with `eoi_level_i` = 0 changes no flag and delivers nothing.
- R7: Each pin counts successive EOI-driven redeliveries. An EOI that finds the pin masked or its request clear resets the count. The redelivery that would bring the count to `STORM_LIMIT` is not made at once: the count returns to zero and the deferral timer starts (`defer_busy_o` high).
- R8: When the deferral timer expires, `DEFER_CYCLES` cycles after it starts, every level-triggered pin that is requested, unmasked and not remote-pending is delivered.
- R9: A pulse on `ent_wr_i` clears the pin's remote-pending flag. If the pin is level-triggered and its request bit is set, a delivery follows.
- R10: A transferred edge-triggered message sets the pin's `delivered_o` bit. A later high strobe on that pin clears it.
- R11: Pending pins are served lowest pin number first, one message per transfer.
- R12: After reset `msg_valid_o` is low and all request, remote-pending and delivered bits are zero. While `msg_valid_o` is high and `msg_ready_i` is low, the message fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb_i | input | NPINS | Per-pin strobe: the pin's level is reported this cycle |
| line_lvl_i | input | NPINS | Reported level, used where the strobe is high |
| ent_mask_i | input | NPINS | Entry mask, 1 = masked |
| ent_level_i | input | NPINS | Entry trigger mode, 1 = level, 0 = edge |
| ent_vector_i | input | NPINS*VEC_W | Entry vectors, pin i at bits [i*VEC_W +: VEC_W] |
| ent_dest_i | input | NPINS*DEST_W | Entry destinations, pin i at bits [i*DEST_W +: DEST_W] |
| ent_dest_mode_i | input | NPINS | Entry destination mode |
| ent_dmode_i | input | NPINS*3 | Entry delivery mode, pin i at bits [i*3 +: 3] |
| ent_wr_i | input | NPINS | Pulse: the entry of this pin was rewritten |
| eoi_valid_i | input | 1 | EOI notification present |
| eoi_vector_i | input | VEC_W | Vector of the EOI |
| eoi_level_i | input | 1 | Trigger mode of the EOI, 1 = level |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Fabric accepts the message this cycle |
| msg_hit_i | input | 1 | At least one destination accepted (sampled at transfer) |
| msg_pin_o | output | PIN_W | Source pin of the message |
| msg_vector_o | output | VEC_W | Message vector |
| msg_dest_o | output | DEST_W | Message destination |
| msg_dest_mode_o | output | 1 | Message destination mode |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_level_o | output | 1 | Message trigger mode, 1 = level |
| drop_o | output | NPINS | Per-pin coalesced/dropped assertion pulse |
| req_o | output | NPINS | Per-pin request bits |
| remote_o | output | NPINS | Per-pin remote-pending flags |
| delivered_o | output | NPINS | Per-pin edge delivered bits |
| defer_busy_o | output | 1 | Storm deferral timer running |

## Verification
The bench builds the engine with four pins, `STORM_LIMIT` = 3 and `DEFER_CYCLES` = 20. With these values a storm on one pin reaches deferral after three EOIs, and the timer expires within a few dozen cycles, so the deferral window and the redelivery at expiry can both be observed. Four pins are enough to mix edge, level and masked entries and to contend two pins for the message slot while the fabric holds ready low.

// File: rtl/ide_pkg.sv
package ide_pkg;
  localparam int DMODE_W = 3;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/ide_pin_track.sv
module ide_pin_track #(
  parameter int STORM_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic lvl_i,
  input  logic mask_i,
  input  logic level_i,
  input  logic eoi_match_i,
  input  logic wr_i,
  input  logic grant_i,
  input  logic busy_i,
  input  logic xfer_i,
  input  logic hit_i,
  input  logic fire_i,
  output logic elig_o,
  output logic defer_o,
  output logic req_o,
  output logic remote_o,
  output logic delivered_o,
  output logic drop_o
);
  localparam int CW = $clog2(STORM_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(STORM_LIMIT - 1);

  logic req_q, rem_q, dlv_q, pend_q, drop_q;
  logic req_n, rem_n, dlv_n, pend_n, drop_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    req_n   = req_q;
    rem_n   = rem_q;
    dlv_n   = dlv_q;
    pend_n  = pend_q;
    cnt_n   = cnt_q;
    drop_n  = 1'b0;
    defer_o = 1'b0;
    if (grant_i) pend_n = 1'b0;
    if (xfer_i) begin
      if (level_i && hit_i) rem_n = 1'b1;
      if (!level_i) dlv_n = 1'b1;
    end
    if (eoi_match_i) begin
      rem_n = 1'b0;
      if (!mask_i && req_q) begin
        if (cnt_q == LAST) begin
          cnt_n   = '0;
          defer_o = 1'b1;
        end else begin
          cnt_n  = cnt_q + 1'b1;
          pend_n = 1'b1;
        end
      end else begin
        cnt_n = '0;
      end
    end
    if (fire_i && level_i && req_q && !mask_i && !rem_n) pend_n = 1'b1;
    if (wr_i) begin
      rem_n = 1'b0;
      if (level_i && req_q) pend_n = 1'b1;
    end
    if (stb_i) begin
      if (lvl_i) begin
        if (!level_i) begin
          if (req_q) drop_n = 1'b1;
          else pend_n = 1'b1;
          dlv_n = 1'b0;
        end else begin
          if (rem_n) drop_n = 1'b1;
          else pend_n = 1'b1;
        end
        req_n = 1'b1;
      end else begin
        req_n = 1'b0;
        if (level_i) pend_n = 1'b0;
      end
    end
    if (mask_i) pend_n = 1'b0;
    if (level_i && rem_n) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      rem_q  <= 1'b0;
      dlv_q  <= 1'b0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q  <= req_n;
      rem_q  <= rem_n;
      dlv_q  <= dlv_n;
      pend_q <= pend_n;
      drop_q <= drop_n;
      cnt_q  <= cnt_n;
    end
  end

  assign elig_o      = pend_q && !mask_i && !busy_i && (!level_i || !rem_q);
  assign req_o       = req_q;
  assign remote_o    = rem_q;
  assign delivered_o = dlv_q;
  assign drop_o      = drop_q;

  // R4
  grant_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> !mask_i);
  // R3
  grant_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && level_i) |-> !rem_q);
  // R5
  hit_sets_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && hit_i && level_i && !eoi_match_i && !wr_i) |=> remote_o);
  // R1
  low_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !lvl_i) |=> !req_o);
  // R7
  storm_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    defer_o |=> (cnt_q == '0));
endmodule

// File: rtl/ide_pick.sv
module ide_pick #(
  parameter int N = 24,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig_i,
  output logic [N-1:0]  onehot_o,
  output logic [PW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = PW'(i);
    end
  end
  assign onehot_o = elig_i & (~elig_i + 1'b1);
  assign any_o    = |elig_i;
endmodule

// File: rtl/ide_defer_timer.sv
module ide_defer_timer #(
  parameter int DEFER_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic fire_o,
  output logic busy_o
);
  localparam int TW = $clog2(DEFER_CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (start_i && cnt_q == '0) cnt_q <= TW'(DEFER_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = (cnt_q == TW'(1));
  assign busy_o = (cnt_q != '0);

  // R8
  fire_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/intr_delivery_engine.sv
module intr_delivery_engine #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2500000,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int DM_W  = ide_pkg::DMODE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        line_stb_i,
  input  logic [NPINS-1:0]        line_lvl_i,
  input  logic [NPINS-1:0]        ent_mask_i,
  input  logic [NPINS-1:0]        ent_level_i,
  input  logic [NPINS*VEC_W-1:0]  ent_vector_i,
  input  logic [NPINS*DEST_W-1:0] ent_dest_i,
  input  logic [NPINS-1:0]        ent_dest_mode_i,
  input  logic [NPINS*DM_W-1:0]   ent_dmode_i,
  input  logic [NPINS-1:0]        ent_wr_i,
  input  logic                    eoi_valid_i,
  input  logic [VEC_W-1:0]        eoi_vector_i,
  input  logic                    eoi_level_i,
  output logic                    msg_valid_o,
  input  logic                    msg_ready_i,
  input  logic                    msg_hit_i,
  output logic [PIN_W-1:0]        msg_pin_o,
  output logic [VEC_W-1:0]        msg_vector_o,
  output logic [DEST_W-1:0]       msg_dest_o,
  output logic                    msg_dest_mode_o,
  output logic [DM_W-1:0]         msg_dmode_o,
  output logic                    msg_level_o,
  output logic [NPINS-1:0]        drop_o,
  output logic [NPINS-1:0]        req_o,
  output logic [NPINS-1:0]        remote_o,
  output logic [NPINS-1:0]        delivered_o,
  output logic                    defer_busy_o
);
  import ide_pkg::*;

  logic [NPINS-1:0] elig, onehot, grant, busy, xfer, defer_req;
  logic [PIN_W-1:0] pick_idx;
  logic             pick_any, load, fire;

  logic              slot_valid;
  logic [PIN_W-1:0]  slot_pin;
  logic [VEC_W-1:0]  slot_vec;
  logic [DEST_W-1:0] slot_dest;
  logic              slot_dmod;
  logic [DM_W-1:0]   slot_dlv;
  trig_e             slot_trig;

  assign load  = (!slot_valid || msg_ready_i) && pick_any;
  assign grant = load ? onehot : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic eoi_hit;
    assign eoi_hit = eoi_valid_i && eoi_level_i && ent_level_i[i] &&
                     (ent_vector_i[i*VEC_W +: VEC_W] == eoi_vector_i);
    assign busy[i] = slot_valid && (slot_pin == PIN_W'(i));
    assign xfer[i] = busy[i] && msg_ready_i;

    ide_pin_track #(.STORM_LIMIT(STORM_LIMIT)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb_i       (line_stb_i[i]),
      .lvl_i       (line_lvl_i[i]),
      .mask_i      (ent_mask_i[i]),
      .level_i     (ent_level_i[i]),
      .eoi_match_i (eoi_hit),
      .wr_i        (ent_wr_i[i]),
      .grant_i     (grant[i]),
      .busy_i      (busy[i]),
      .xfer_i      (xfer[i]),
      .hit_i       (msg_hit_i),
      .fire_i      (fire),
      .elig_o      (elig[i]),
      .defer_o     (defer_req[i]),
      .req_o       (req_o[i]),
      .remote_o    (remote_o[i]),
      .delivered_o (delivered_o[i]),
      .drop_o      (drop_o[i])
    );
  end

  ide_pick #(.N(NPINS)) u_pick (
    .elig_i   (elig),
    .onehot_o (onehot),
    .idx_o    (pick_idx),
    .any_o    (pick_any)
  );

  ide_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (|defer_req),
    .fire_o  (fire),
    .busy_o  (defer_busy_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_pin   <= '0;
      slot_vec   <= '0;
      slot_dest  <= '0;
      slot_dmod  <= 1'b0;
      slot_dlv   <= '0;
      slot_trig  <= TRIG_EDGE;
    end else if (load) begin
      slot_valid <= 1'b1;
      slot_pin   <= pick_idx;
      slot_vec   <= ent_vector_i[pick_idx*VEC_W +: VEC_W];
      slot_dest  <= ent_dest_i[pick_idx*DEST_W +: DEST_W];
      slot_dmod  <= ent_dest_mode_i[pick_idx];
      slot_dlv   <= ent_dmode_i[pick_idx*DM_W +: DM_W];
      slot_trig  <= ent_level_i[pick_idx] ? TRIG_LEVEL : TRIG_EDGE;
    end else if (msg_ready_i) begin
      slot_valid <= 1'b0;
    end
  end

  assign msg_valid_o     = slot_valid;
  assign msg_pin_o       = slot_pin;
  assign msg_vector_o    = slot_vec;
  assign msg_dest_o      = slot_dest;
  assign msg_dest_mode_o = slot_dmod;
  assign msg_dmode_o     = slot_dlv;
  assign msg_level_o     = (slot_trig == TRIG_LEVEL);

  // R12
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_pin_o) &&
      $stable(msg_vector_o) && $stable(msg_dest_o) && $stable(msg_level_o)));
  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R11
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (elig[pick_idx] && ((elig & ((NPINS'(1) << pick_idx) - 1'b1)) == '0)));
endmodule

// File: tb/intr_delivery_engine_test.sv
module intr_delivery_engine_test;
  localparam int N = 4;
  localparam int VW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] stb = '0, lvl = '0, mask, level, dmod, wr = '0;
  logic [VW-1:0] vec_a [N];
  logic [DW-1:0] dst_a [N];
  logic eoi_v = 1'b0, eoi_l = 1'b0, ready = 1'b1, hit = 1'b1;
  logic [VW-1:0] eoi_vec = '0;

  logic msg_valid, msg_dm, msg_lv, busy_t;
  logic [1:0] msg_pin;
  logic [VW-1:0] msg_vec;
  logic [DW-1:0] msg_dst;
  logic [2:0] msg_dlv;
  logic [N-1:0] drop, req, remote, dlvd;

  intr_delivery_engine #(.NPINS(N), .VEC_W(VW), .DEST_W(DW),
    .STORM_LIMIT(3), .DEFER_CYCLES(20)) uut (
    .clk(clk), .rst_n(rst_n), .line_stb_i(stb), .line_lvl_i(lvl),
    .ent_mask_i(mask), .ent_level_i(level),
    .ent_vector_i({vec_a[3], vec_a[2], vec_a[1], vec_a[0]}),
    .ent_dest_i({dst_a[3], dst_a[2], dst_a[1], dst_a[0]}),
    .ent_dest_mode_i(dmod), .ent_dmode_i(12'h000), .ent_wr_i(wr),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .eoi_level_i(eoi_l),
    .msg_valid_o(msg_valid), .msg_ready_i(ready), .msg_hit_i(hit),
    .msg_pin_o(msg_pin), .msg_vector_o(msg_vec), .msg_dest_o(msg_dst),
    .msg_dest_mode_o(msg_dm), .msg_dmode_o(msg_dlv), .msg_level_o(msg_lv),
    .drop_o(drop), .req_o(req), .remote_o(remote), .delivered_o(dlvd),
    .defer_busy_o(busy_t));

  int checks = 0, errors = 0, rx = 0, snap = 0;
  logic done = 1'b0;
  logic [17:0] exp_q [$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_msg(input int p);
    exp_q.push_back({2'(p), vec_a[p], dst_a[p]});
  endtask

  task automatic strobe(input logic [N-1:0] pins, input logic l);
    @(negedge clk);
    stb = pins;
    lvl = l ? pins : '0;
    @(negedge clk);
    stb = '0;
    lvl = '0;
  endtask

  task automatic eoi(input logic [VW-1:0] v, input logic l);
    @(negedge clk);
    eoi_v = 1'b1; eoi_vec = v; eoi_l = l;
    @(negedge clk);
    eoi_v = 1'b0;
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: one transfer per negedge where valid and ready are both high
  always @(negedge clk) begin
    if (rst_n && msg_valid && ready) begin
      rx++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected message", {msg_pin, msg_vec, msg_dst}, 0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check({msg_pin, msg_vec, msg_dst} == e, "R11 message content",
              {msg_pin, msg_vec, msg_dst}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mask  = 4'b0010;
    level = 4'b1100;
    dmod  = '0;
    vec_a[0] = 8'h30; vec_a[1] = 8'h31; vec_a[2] = 8'h42; vec_a[3] = 8'h53;
    dst_a[0] = 8'h01; dst_a[1] = 8'h02; dst_a[2] = 8'h05; dst_a[3] = 8'h07;
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R12 reset state
    check(!msg_valid && req == 0 && remote == 0 && dlvd == 0, "R12 reset",
          {msg_valid, req, remote, dlvd}, 0);

    // R2 / R10 first edge delivered
    expect_msg(0);
    strobe(4'b0001, 1'b1);
    cyc(5);
    drained("R2 edge delivery");
    check(dlvd[0] == 1'b1, "R10 delivered set", dlvd[0], 1);

    // R2 coalesced edge
    snap = rx;
    strobe(4'b0001, 1'b1);
    check(drop[0] == 1'b1, "R2 drop pulse", drop[0], 1);
    cyc(5);
    check(rx == snap, "R2 no delivery when coalesced", rx, snap);
    check(dlvd[0] == 1'b0, "R10 delivered cleared", dlvd[0], 0);

    // R1 low clears
    strobe(4'b0001, 1'b0);
    check(req[0] == 1'b0, "R1 request cleared", req[0], 0);
    cyc(4);
    check(rx == snap, "R1 nothing delivered", rx, snap);

    // R4 masked pin
    strobe(4'b0010, 1'b1);
    cyc(5);
    check(rx == snap, "R4 masked no delivery", rx, snap);
    check(req[1] == 1'b1, "R4 request kept", req[1], 1);

    // R5 level delivery sets remote
    expect_msg(2);
    strobe(4'b0100, 1'b1);
    cyc(5);
    drained("R5 level delivery");
    check(remote[2] == 1'b1, "R5 remote set", remote[2], 1);

    // R3 assertion while remote pending
    snap = rx;
    strobe(4'b0100, 1'b1);
    check(drop[2] == 1'b1, "R3 drop pulse", drop[2], 1);
    cyc(5);
    check(rx == snap, "R3 no delivery", rx, snap);

    // R6 edge-mode EOI ignored
    eoi(8'h42, 1'b0);
    cyc(5);
    check(remote[2] == 1'b1 && rx == snap, "R6 edge EOI ignored", {remote[2], rx[7:0]}, {1'b1, snap[7:0]});

    // R6 / R7 redeliveries 1 and 2
    expect_msg(2);
    eoi(8'h42, 1'b1);
    cyc(5);
    drained("R6 redelivery");
    expect_msg(2);
    eoi(8'h42, 1'b1);
    cyc(5);
    drained("R7 second redelivery");

    // R7 third reaches limit: deferred
    snap = rx;
    eoi(8'h42, 1'b1);
    cyc(8);
    check(rx == snap, "R7 redelivery deferred", rx, snap);
    check(busy_t == 1'b1, "R7 defer timer running", busy_t, 1);
    check(remote[2] == 1'b0, "R6 remote cleared by EOI", remote[2], 0);
    expect_msg(2);
    cyc(20);
    drained("R8 delivery at expiry");

    // R7 count resets when pin idle
    expect_msg(2);
    eoi(8'h42, 1'b1);
    cyc(5);
    drained("R7 count restarted after deferral");
    strobe(4'b0100, 1'b0);
    snap = rx;
    eoi(8'h42, 1'b1);
    cyc(5);
    check(rx == snap && remote[2] == 1'b0, "R7 idle EOI no delivery",
          {remote[2], rx[7:0]}, {1'b0, snap[7:0]});
    expect_msg(2);
    strobe(4'b0100, 1'b1);
    cyc(5);
    expect_msg(2);
    eoi(8'h42, 1'b1);
    cyc(5);
    expect_msg(2);
    eoi(8'h42, 1'b1);
    cyc(5);
    drained("R7 count reset by idle EOI");
    strobe(4'b0100, 1'b0);
    eoi(8'h42, 1'b1);
    cyc(3);

    // R11 / R12 priority under back-pressure
    ready = 1'b0;
    expect_msg(0);
    expect_msg(3);
    strobe(4'b1001, 1'b1);
    cyc(3);
    check(msg_valid && msg_pin == 2'd0, "R11 lowest pin first", msg_pin, 0);
    cyc(3);
    check(msg_valid && msg_pin == 2'd0 && msg_vec == 8'h30, "R12 held while stalled",
          msg_vec, 8'h30);
    ready = 1'b1;
    cyc(6);
    drained("R11 both served");
    check(remote[3] == 1'b1, "R5 remote on pin 3", remote[3], 1);

    // R9 reconfiguration delivers level pin with request set
    @(negedge clk);
    mask[1] = 1'b0; level[1] = 1'b1; wr = 4'b0010;
    expect_msg(1);
    @(negedge clk);
    wr = '0;
    cyc(5);
    drained("R9 reconfig delivery");
    check(remote[1] == 1'b1, "R9 remote after accept", remote[1], 1);

    // R5 no hit keeps remote clear
    hit = 1'b0;
    expect_msg(3);
    eoi(8'h53, 1'b1);
    cyc(5);
    drained("R6 pin 3 redelivery");
    check(remote[3] == 1'b0, "R5 no hit remote clear", remote[3], 0);

    // R9 rewrite clears remote
    @(negedge clk);
    wr = 4'b0010;
    expect_msg(1);
    @(negedge clk);
    wr = '0;
    cyc(5);
    drained("R9 rewrite redelivery");
    check(remote[1] == 1'b0, "R9 remote cleared", remote[1], 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule